// File: doc/BRIEF.md
# Separate-Port SRAM with Alternating Arbitration

This block is a synchronous memory with one read request port and one write request port, each carrying its own active-low select and address, in front of a single storage array. On every rising clock edge it starts at most one transaction. When only one port asks, that port is served at once. When both ask on the same edge, the choice depends on what was started in the cycle before. After a read the write wins. After a write, or after a cycle with nothing started, the read wins. Holding both selects low from idle therefore yields read, write, read, write, and so on.

Each port has a combinational accept strobe. A request that loses is not queued, so the requester holds its select and address until the strobe shows it was taken. Writes go through a one-entry pending stage before they reach the array. Each byte lane has an active-low enable. Read data comes back a fixed two cycles after acceptance with a one-cycle valid flag. A read always sees every write accepted before it, including a write still waiting in the pending stage. A synchronous active-high reset clears the history and the valid flags but keeps the array contents.

Top module: `sepport_sram`

## Requirements
- R1: In any cycle at most one of `rd_ack` and `wr_ack` is high, and an accept strobe is high only while its own select is low.
- R2: When both selects are low and neither a read nor a write was accepted in the previous cycle, the read is accepted.
- R3: When both selects are low and a read was accepted in the previous cycle, the write is accepted.
- R4: When both selects are low and a write was accepted in the previous cycle, the read is accepted. Holding both selects low from idle gives accepts in the order read, write, read, write.
- R5: When only one select is low, that request is accepted whatever the history. The idle state of the other port has no effect on it.
- R6: For a read accepted in cycle n, `rd_valid` is high in cycle n+2 for exactly one cycle, with `rd_data` holding the word.
- R7: A read that has been accepted completes even if `rd_sel_n` is raised in the following cycle.
- R8: A read accepted in the cycle directly after a write to the same address returns the newly written bytes.
- R9: `wr_be_n[i]` low enables byte lane i (`wr_data[8i+7:8i]`). A byte whose enable is high keeps its previous contents. This holds both in the array and in a forwarded result.
- R10: While `rst` is high both accept strobes are low. After reset `rd_valid` is low and the history is idle, so the first contested request is a read, and earlier array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel_n | input | 1 | Read request, active low |
| rd_addr | input | AW | Read word address |
| wr_sel_n | input | 1 | Write request, active low |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| wr_be_n | input | DW/BW | Byte-lane write enables, active low |
| rd_ack | output | 1 | Read request accepted at the coming edge |
| wr_ack | output | 1 | Write request accepted at the coming edge |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | `rd_data` valid this cycle |

## Verification
A wrong history state shows up on the accept strobes in the very next cycle in which both selects are low. The alternation then breaks or starts with a write, and the tests hold both selects low from a known history to catch this. A stale or wrong pending-write entry shows up two cycles after a back-to-back write and read of one address, as wrong bytes in `rd_data`. A fault in the read valid pipeline shows up as `rd_valid` rising one cycle early or late, or lasting two cycles. Each of these is checked at the cycle where the requirements place it.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic [1:0] {
      LAST_NONE = 2'd0,
      LAST_RD   = 2'd1,
      LAST_WR   = 2'd2
   } last_op_t;
endpackage

// File: rtl/ssr_arb.sv
module ssr_arb
   import ssr_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic rd_req,
   input  logic wr_req,
   output logic rd_go,
   output logic wr_go
);
   last_op_t last_q;

   always_comb begin
      rd_go = 1'b0;
      wr_go = 1'b0;
      if (!rst) begin
         if (rd_req && wr_req) begin
            if (last_q == LAST_RD) wr_go = 1'b1;
            else                   rd_go = 1'b1;
         end else begin
            rd_go = rd_req;
            wr_go = wr_req;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        last_q <= LAST_NONE;
      else if (rd_go) last_q <= LAST_RD;
      else if (wr_go) last_q <= LAST_WR;
      else            last_q <= LAST_NONE;
   end
endmodule

// File: rtl/ssr_lane.sv
module ssr_lane #(
   parameter int AW = 6,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          commit_en,
   input  logic [AW-1:0] commit_addr,
   input  logic [BW-1:0] commit_byte,
   input  logic          rd_fire,
   input  logic [AW-1:0] rd_addr,
   input  logic          fwd_en,
   input  logic [BW-1:0] fwd_byte,
   output logic [BW-1:0] rd_byte
);
   localparam int DEPTH = 1 << AW;

   logic [BW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (commit_en) store[commit_addr] <= commit_byte;
      if (rd_fire)   rd_byte <= fwd_en ? fwd_byte : store[rd_addr];
   end
endmodule

// File: rtl/sepport_sram.sv
module sepport_sram
   import ssr_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 32,
   parameter int BW = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rd_sel_n,
   input  logic [AW-1:0]    rd_addr,
   input  logic             wr_sel_n,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [DW/BW-1:0] wr_be_n,
   output logic             rd_ack,
   output logic             wr_ack,
   output logic [DW-1:0]    rd_data,
   output logic             rd_valid
);
   localparam int NB = DW / BW;

   generate
      if (DW % BW != 0) begin : g_bad_width
         $error("sepport_sram: DW must be a multiple of BW");
      end
      if (AW < 1 || AW > 12) begin : g_bad_depth
         $error("sepport_sram: AW out of range");
      end
   endgenerate

   logic          rd_go, wr_go;
   logic          pend_vld;
   logic [AW-1:0] pend_addr;
   logic [DW-1:0] pend_data;
   logic [NB-1:0] pend_be_n;
   logic          s1_vld;
   logic [DW-1:0] s1_data;
   logic          pend_hit;

   ssr_arb u_arb (
      .clk    (clk),
      .rst    (rst),
      .rd_req (!rd_sel_n),
      .wr_req (!wr_sel_n),
      .rd_go  (rd_go),
      .wr_go  (wr_go)
   );

   assign rd_ack   = rd_go;
   assign wr_ack   = wr_go;
   assign pend_hit = pend_vld && (pend_addr == rd_addr);

   always_ff @(posedge clk) begin
      if (rst) pend_vld <= 1'b0;
      else     pend_vld <= wr_go;
      if (wr_go) begin
         pend_addr <= wr_addr;
         pend_data <= wr_data;
         pend_be_n <= wr_be_n;
      end
   end

   genvar b;
   generate
      for (b = 0; b < NB; b++) begin : g_lane
         ssr_lane #(.AW(AW), .BW(BW)) u_lane (
            .clk         (clk),
            .commit_en   (pend_vld && !pend_be_n[b]),
            .commit_addr (pend_addr),
            .commit_byte (pend_data[b*BW +: BW]),
            .rd_fire     (rd_go),
            .rd_addr     (rd_addr),
            .fwd_en      (pend_hit && !pend_be_n[b]),
            .fwd_byte    (pend_data[b*BW +: BW]),
            .rd_byte     (s1_data[b*BW +: BW])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld   <= 1'b0;
         rd_valid <= 1'b0;
      end else begin
         s1_vld   <= rd_go;
         rd_valid <= s1_vld;
      end
      if (s1_vld) rd_data <= s1_data;
   end
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk (
   input logic clk,
   input logic rst,
   input logic rd_sel_n,
   input logic wr_sel_n,
   input logic rd_ack,
   input logic wr_ack,
   input logic rd_valid
);
   AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
      !(rd_ack && wr_ack)); // R1
   AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
      (rd_ack |-> !rd_sel_n) and (wr_ack |-> !wr_sel_n)); // R1
   AST_IDLE_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
      (!rd_sel_n && !wr_sel_n && !$past(rd_ack) && !$past(wr_ack)) |-> rd_ack); // R2
   AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      (!rd_sel_n && !wr_sel_n && $past(rd_ack)) |-> wr_ack); // R3
   AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      (!rd_sel_n && !wr_sel_n && $past(wr_ack)) |-> rd_ack); // R4
   AST_LONE_GRANT: assert property (@(posedge clk) disable iff (rst)
      ((!rd_sel_n && wr_sel_n) |-> rd_ack) and ((rd_sel_n && !wr_sel_n) |-> wr_ack)); // R5
   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_ack, 2) && !$past(rst)) |-> rd_valid); // R6
   AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> $past(rd_ack, 2)); // R6
endmodule

bind sepport_sram ssr_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .rd_sel_n (rd_sel_n),
   .wr_sel_n (wr_sel_n),
   .rd_ack   (rd_ack),
   .wr_ack   (wr_ack),
   .rd_valid (rd_valid)
);

// File: tb/sim_sepport_sram.sv
`timescale 1ns/1ps
module sim_sepport_sram;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          rd_sel_n, wr_sel_n;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] wr_data;
   logic [NB-1:0] wr_be_n;
   logic          rd_ack, wr_ack, rd_valid;
   logic [DW-1:0] rd_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sepport_sram #(.AW(AW), .DW(DW), .BW(8)) u0 (
      .clk(clk), .rst(rst),
      .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
      .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be_n(wr_be_n),
      .rd_ack(rd_ack), .wr_ack(wr_ack),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle_in();
      rd_sel_n = 1'b1; wr_sel_n = 1'b1;
   endtask

   // single write, expects lone grant (R5)
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be);
      rd_sel_n = 1'b1; wr_sel_n = 1'b0; wr_addr = a; wr_data = d; wr_be_n = be;
      #1;
      chk(wr_ack && !rd_ack, "R5 lone write accepted", {30'd0, rd_ack, wr_ack}, 32'd1);
      tick();
      idle_in();
   endtask

   // single read, deselect right after accept (R7), check timing (R6)
   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      rd_sel_n = 1'b0; wr_sel_n = 1'b1; rd_addr = a;
      #1;
      chk(rd_ack && !wr_ack, "R5 lone read accepted", {30'd0, rd_ack, wr_ack}, 32'd2);
      tick();
      idle_in();
      chk(!rd_valid, "R6 valid not early", {31'd0, rd_valid}, 32'd0);
      tick();
      chk(rd_valid, "R7 deselected read completes", {31'd0, rd_valid}, 32'd1);
      chk(rd_data == exp, req, rd_data, exp);
      tick();
      chk(!rd_valid, "R6 valid one cycle", {31'd0, rd_valid}, 32'd0);
   endtask

   task automatic t_reset();
      rst = 1'b1; rd_sel_n = 1'b0; wr_sel_n = 1'b0;
      rd_addr = '0; wr_addr = '0; wr_data = '0; wr_be_n = '0;
      tick(); tick();
      #1;
      chk(!rd_ack && !wr_ack, "R10 no accept in reset", {30'd0, rd_ack, wr_ack}, 32'd0);
      chk(!rd_valid, "R10 valid low in reset", {31'd0, rd_valid}, 32'd0);
      idle_in();
      tick();
      rst = 1'b0;
      tick();
   endtask

   task automatic t_alternate();
      bit exp_rd;
      idle_in();
      tick();
      rd_sel_n = 1'b0; wr_sel_n = 1'b0; rd_addr = 6'd3; wr_addr = 6'd9;
      wr_data = 32'h0BAD_F00D; wr_be_n = '0;
      for (int i = 0; i < 6; i++) begin
         exp_rd = (i % 2 == 0);
         #1;
         if (i == 0)
            chk(rd_ack && !wr_ack, "R2 read first from idle", {30'd0, rd_ack, wr_ack}, 32'd2);
         else if (exp_rd)
            chk(rd_ack && !wr_ack, "R4 read after write", {30'd0, rd_ack, wr_ack}, 32'd2);
         else
            chk(wr_ack && !rd_ack, "R3 write after read", {30'd0, rd_ack, wr_ack}, 32'd1);
         chk(!(rd_ack && wr_ack), "R1 single start", {30'd0, rd_ack, wr_ack}, 32'd0);
         tick();
      end
      idle_in();
      tick(); tick();
   endtask

   task automatic t_forward();
      do_write(6'd7, 32'h1122_3344, 4'b0000);
      tick();
      do_write(6'd7, 32'hAABB_CCDD, 4'b1010);
      do_read(6'd7, 32'h11BB_33DD, "R8 forwarded partial write");
      do_read(6'd7, 32'h11BB_33DD, "R9 disabled bytes kept in array");
   endtask

   task automatic t_reset_keep();
      rst = 1'b1;
      tick();
      rst = 1'b0;
      rd_sel_n = 1'b0; wr_sel_n = 1'b0; rd_addr = 6'd3; wr_addr = 6'd20;
      #1;
      chk(rd_ack && !wr_ack, "R10 history idle after reset", {30'd0, rd_ack, wr_ack}, 32'd2);
      idle_in();
      tick();
      tick(); tick();
      do_read(6'd3, 32'hCAFE_0003, "R10 contents kept over reset");
   endtask

   initial begin
      t_reset();
      do_write(6'd3, 32'hCAFE_0003, 4'b0000);
      tick();
      do_read(6'd3, 32'hCAFE_0003, "R6 read data from array");
      t_alternate();
      do_read(6'd9, 32'h0BAD_F00D, "R3 alternated write landed");
      t_forward();
      t_reset_keep();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule